// File: doc/BRIEF.md
# Row-Buffered DRAM Array Controller

This block is a cycle-level model of a small dynamic memory array and the sequencer that serves it. A requester presents a full cell address, a read/write flag and, for writes, a data byte. The sequencer splits the address into a row index and a column index and sends them one after the other over a narrow shared address bus. A row strobe copies the addressed row from the array into an internal row buffer. A column strobe then either moves one cell of that buffer to the read-data port or overwrites that cell with the write data.

The row buffer stays open after an access. A later access to the same row skips the row step. A buffer that has been written is copied back to the array before any other row replaces it. A free-running timer raises a refresh request once per refresh slot. The request is served between accesses and refreshes the rows in turn. A refresh passes through the row buffer, so it leaves no row open.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `rowStrobe`, `colStrobe`, `refStrobe` and `done` are low and `reqReady` is high.
- R2: The row index is the upper `log2(ROWS)` bits of `reqAddr` and the column index is the lower `log2(COLS)` bits. While `rowStrobe` is high, `memAddr` carries the row index. While `colStrobe` is high, `memAddr` carries the column index. A `rowStrobe` cycle is always followed at once by a `colStrobe` cycle.
- R3: At most one of `rowStrobe`, `colStrobe` and `refStrobe` is high in any cycle.
- R4: `done` is high for exactly the one cycle that follows each `colStrobe` cycle, and at no other time.
- R5: An access whose row is already open in the buffer issues no `rowStrobe`, and its `done` arrives 2 cycles after the accepting edge.
- R6: A read returns, on `rdData` in its `done` cycle, the byte most recently written to that address, whichever rows were opened in between.
- R7: An access that misses the open row has `done` 3 cycles after acceptance when the buffer is unmodified. It has `done` 4 cycles after acceptance when the buffer holds written data that must first be copied back.
- R8: Refresh requests occur every `REFRESH_CYCLES` clock cycles. Each served request shows one `refStrobe` cycle with `memAddr` equal to the row being refreshed, and the rows follow the order 0, 1, ..., ROWS-1, 0, and so on. Successive refreshes with no traffic are exactly `REFRESH_CYCLES` apart.
- R9: A pending refresh holds `reqReady` low. The first access after a refresh always opens its row with `rowStrobe`, and refresh never loses written data.
- R10: Only one command is in flight. From the accepting edge until its `done` cycle, `reqReady` is low.
- R11: `rdData` changes only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command offered |
| reqReady | output | 1 | Command accepted at this edge when `reqValid` is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | log2(ROWS)+log2(COLS) | Cell address: row in the upper bits, column in the lower bits |
| reqWdata | input | WIDTH | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | WIDTH | Read result, valid in the `done` cycle |
| memAddr | output | max(log2 ROWS, log2 COLS) | Shared multiplexed row/column address bus |
| rowStrobe | output | 1 | Row open: addressed row copied into the buffer |
| colStrobe | output | 1 | Column access on the buffer |
| refStrobe | output | 1 | Refresh of the row on `memAddr` |

## Verification
The array is written in address order. This mixes buffer hits inside a row with copy-back misses at each row boundary. It is then read column by column, so every access changes row, and read again row by row, so most accesses hit. The latency measured for each pass separates hits, clean misses and dirty misses. A second overwrite is read back with a stride that visits the cells out of order. This shows that copy-back never loses a byte. Refreshes fall between these accesses at a short period, so hit/miss predictions must account for the closed row. An idle stretch after a dirty write measures the exact refresh spacing and row order. It then confirms that the written byte survived and that the next access reopens its row.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_ACT,
    ST_COL,
    ST_REF
  } ctrlState_t;

  // Strobes from the sequencer to the storage path
  typedef struct packed {
    logic capture;   // latch write byte at command acceptance
    logic storeRow;  // copy row buffer back into the array
    logic loadRow;   // copy an array row into the row buffer
    logic colRead;   // move one buffer cell to the read register
    logic colWrite;  // overwrite one buffer cell
  } dpStrobe_t;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD = 400
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (count == CNT_W'(PERIOD - 1)) begin
      count <= '0;
      tick  <= 1'b1;
    end else begin
      count <= count + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int ADDR_W = 4,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              refTick,
  output logic              reqReady,
  output logic              done,
  output dpStrobe_t         strb,
  output logic [ROW_W-1:0]  arrRow,
  output logic [COL_W-1:0]  colSel,
  output logic [PORT_W-1:0] memAddr,
  output logic              rowStrobe,
  output logic              colStrobe,
  output logic              refStrobe
);
  ctrlState_t       state;
  logic             cmdWrite;
  logic [ROW_W-1:0] cmdRow;
  logic [COL_W-1:0] cmdCol;
  logic [ROW_W-1:0] openRow;
  logic [ROW_W-1:0] refRow;
  logic             bufOpen;
  logic             bufDirty;
  logic             refPending;
  logic             wbThenRef;

  logic [ROW_W-1:0] inRow;
  logic [COL_W-1:0] inCol;
  logic             accept;
  logic             rowHit;

  assign inRow  = reqAddr[ADDR_W-1:COL_W];
  assign inCol  = reqAddr[COL_W-1:0];
  assign reqReady = (state == ST_IDLE) && !refPending;
  assign accept = reqValid && reqReady;
  assign rowHit = bufOpen && (openRow == inRow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cmdWrite   <= 1'b0;
      cmdRow     <= '0;
      cmdCol     <= '0;
      openRow    <= '0;
      refRow     <= '0;
      bufOpen    <= 1'b0;
      bufDirty   <= 1'b0;
      refPending <= 1'b0;
      wbThenRef  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (refTick) refPending <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (refPending) begin
            if (bufOpen && bufDirty) begin
              wbThenRef <= 1'b1;
              state     <= ST_WBACK;
            end else begin
              state <= ST_REF;
            end
          end else if (accept) begin
            cmdWrite <= reqWrite;
            cmdRow   <= inRow;
            cmdCol   <= inCol;
            if (rowHit) begin
              state <= ST_COL;
            end else if (bufOpen && bufDirty) begin
              wbThenRef <= 1'b0;
              state     <= ST_WBACK;
            end else begin
              state <= ST_ACT;
            end
          end
        end
        ST_WBACK: begin
          bufDirty <= 1'b0;
          state    <= wbThenRef ? ST_REF : ST_ACT;
        end
        ST_ACT: begin
          openRow  <= cmdRow;
          bufOpen  <= 1'b1;
          bufDirty <= 1'b0;
          state    <= ST_COL;
        end
        ST_COL: begin
          if (cmdWrite) bufDirty <= 1'b1;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_REF: begin
          bufOpen  <= 1'b0;
          bufDirty <= 1'b0;
          refRow   <= (refRow == ROW_W'(ROWS - 1)) ? '0 : refRow + 1'b1;
          if (!refTick) refPending <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.capture  = (state == ST_IDLE) && accept;
    strb.storeRow = (state == ST_WBACK);
    strb.loadRow  = (state == ST_ACT) || (state == ST_REF);
    strb.colRead  = (state == ST_COL) && !cmdWrite;
    strb.colWrite = (state == ST_COL) && cmdWrite;
  end

  always_comb begin
    unique case (state)
      ST_WBACK: arrRow = openRow;
      ST_REF:   arrRow = refRow;
      default:  arrRow = cmdRow;
    endcase
  end

  assign colSel = cmdCol;

  always_comb begin
    unique case (state)
      ST_ACT:  memAddr = PORT_W'(cmdRow);
      ST_COL:  memAddr = PORT_W'(cmdCol);
      ST_REF:  memAddr = PORT_W'(refRow);
      default: memAddr = '0;
    endcase
  end

  assign rowStrobe = (state == ST_ACT);
  assign colStrobe = (state == ST_COL);
  assign refStrobe = (state == ST_REF);
endmodule

// File: rtl/dram_array_path.sv
module dram_array_path
  import dram_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  parameter int ROW_W = 2,
  parameter int COL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [ROW_W-1:0] arrRow,
  input  logic [COL_W-1:0] colSel,
  input  logic [WIDTH-1:0] reqWdata,
  output logic [WIDTH-1:0] rdData
);
  typedef logic [COLS-1:0][WIDTH-1:0] rowWord_t;

  rowWord_t         cells [ROWS];
  rowWord_t         rowBuf;
  logic [WIDTH-1:0] wdataQ;

  // Storage and buffer carry no reset, as a real array would not
  always_ff @(posedge clk) begin
    if (strb.capture)  wdataQ <= reqWdata;
    if (strb.storeRow) cells[arrRow] <= rowBuf;
    if (strb.loadRow)  rowBuf <= cells[arrRow];
    if (strb.colWrite) rowBuf[colSel] <= wdataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.colRead) begin
      rdData <= rowBuf[colSel];
    end
  end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_pkg::*;
#(
  parameter int ROWS           = 4,
  parameter int COLS           = 4,
  parameter int WIDTH          = 8,
  parameter int REFRESH_CYCLES = 400,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int PORT_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WIDTH-1:0]  reqWdata,
  output logic              done,
  output logic [WIDTH-1:0]  rdData,
  output logic [PORT_W-1:0] memAddr,
  output logic              rowStrobe,
  output logic              colStrobe,
  output logic              refStrobe
);
  dpStrobe_t        strb;
  logic [ROW_W-1:0] arrRow;
  logic [COL_W-1:0] colSel;
  logic             refTick;

  dram_refresh_timer #(.PERIOD(REFRESH_CYCLES)) u_timer (
    .clk  (clk),
    .rstN (rstN),
    .tick (refTick)
  );

  dram_seq_ctrl #(
    .ROWS(ROWS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .refTick   (refTick),
    .reqReady  (reqReady),
    .done      (done),
    .strb      (strb),
    .arrRow    (arrRow),
    .colSel    (colSel),
    .memAddr   (memAddr),
    .rowStrobe (rowStrobe),
    .colStrobe (colStrobe),
    .refStrobe (refStrobe)
  );

  dram_array_path #(
    .ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .arrRow   (arrRow),
    .colSel   (colSel),
    .reqWdata (reqWdata),
    .rdData   (rdData)
  );
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
  parameter int ROWS           = 4,
  parameter int WIDTH          = 8,
  parameter int REFRESH_CYCLES = 400,
  parameter int PORT_W         = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              done,
  input logic [WIDTH-1:0]  rdData,
  input logic [PORT_W-1:0] memAddr,
  input logic              rowStrobe,
  input logic              colStrobe,
  input logic              refStrobe
);
  localparam int SLACK = 8;

  int  sinceRef;
  int  expRef;
  logic closedByRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRef    <= 0;
      expRef      <= 0;
      closedByRef <= 1'b0;
    end else begin
      sinceRef <= refStrobe ? 0 : sinceRef + 1;
      if (refStrobe) begin
        expRef      <= (expRef == ROWS - 1) ? 0 : expRef + 1;
        closedByRef <= 1'b1;
      end else if (rowStrobe) begin
        closedByRef <= 1'b0;
      end
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rowStrobe, colStrobe, refStrobe}));

  // R2
  row_then_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe |=> colStrobe);

  // R4
  col_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe |=> done);

  // R4
  done_after_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(colStrobe));

  // R10
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R11
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> done);

  // R8
  ref_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    refStrobe |-> (int'(memAddr) == expRef));

  // R8
  ref_interval_chk: assert property (@(posedge clk) disable iff (!rstN)
    sinceRef <= REFRESH_CYCLES + SLACK);

  // R9
  reopen_after_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe |-> !closedByRef);
endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(
  .ROWS(ROWS), .WIDTH(WIDTH), .REFRESH_CYCLES(REFRESH_CYCLES), .PORT_W(PORT_W)
) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .done(done), .rdData(rdData), .memAddr(memAddr), .rowStrobe(rowStrobe),
  .colStrobe(colStrobe), .refStrobe(refStrobe)
);

// File: tb/dram_page_ctrl_test.sv
module dram_page_ctrl_test;
  localparam int ROWS = 4, COLS = 4, WIDTH = 8, REF_CYC = 50;
  localparam int COL_W = 2, ADDR_W = 4, PORT_W = 2, CELLS = ROWS * COLS;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [WIDTH-1:0] reqWdata = '0;
  logic reqReady, done, rowStrobe, colStrobe, refStrobe;
  logic [WIDTH-1:0] rdData;
  logic [PORT_W-1:0] memAddr;

  always #2 clk = ~clk;

  dram_page_ctrl #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .REFRESH_CYCLES(REF_CYC)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .done(done),
    .rdData(rdData), .memAddr(memAddr), .rowStrobe(rowStrobe),
    .colStrobe(colStrobe), .refStrobe(refStrobe));

  int checks = 0, errors = 0, cyc = 0;
  int model [CELLS];
  bit mOpen = 0, mDirty = 0;
  int mRow = 0, expRefRow = 0, refSeen = 0, prevRefCyc = -1, lastGap = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Refresh monitor: order, spacing and effect on the open row
  always @(negedge clk) begin
    if (rstN && refStrobe) begin
      check(int'(memAddr) == expRefRow, "R8", "refresh row", int'(memAddr), expRefRow);
      expRefRow = (expRefRow + 1) % ROWS;
      if (prevRefCyc >= 0) lastGap = cyc - prevRefCyc;
      prevRefCyc = cyc;
      mOpen = 0;
      mDirty = 0;
      refSeen++;
    end
  end

  task automatic doOp(input bit wr, input int addr, input int wdata);
    int row, col, expLat, lat;
    bit hit, sawRow;
    row = addr >> COL_W;
    col = addr % COLS;
    @(negedge clk);
    reqWrite = wr; reqAddr = ADDR_W'(addr); reqWdata = WIDTH'(wdata); reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    hit = mOpen && (mRow == row);
    expLat = hit ? 2 : ((mOpen && mDirty) ? 4 : 3);
    if (!hit) mDirty = 0;
    mOpen = 1; mRow = row;
    if (wr) begin mDirty = 1; model[addr] = wdata & 255; end
    lat = 0; sawRow = 0;
    forever begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (rowStrobe) begin
        sawRow = 1;
        check(int'(memAddr) == row, "R2", "row on bus", int'(memAddr), row);
      end
      if (colStrobe) check(int'(memAddr) == col, "R2", "column on bus", int'(memAddr), col);
      if (done) break;
      check(!reqReady, "R10", "ready while busy", int'(reqReady), 0);
      if (lat > 10) begin
        check(0, "R4", "done never came", lat, expLat);
        break;
      end
    end
    if (hit) check(lat == expLat, "R5", "hit latency", lat, expLat);
    else     check(lat == expLat, "R7", "miss latency", lat, expLat);
    check(sawRow == !hit, "R5", "row strobe use", int'(sawRow), int'(!hit));
    if (!wr) check(int'(rdData) == model[addr], "R6", "read data", int'(rdData), model[addr]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(!rowStrobe && !colStrobe && !refStrobe, "R1", "strobes in reset",
          int'({rowStrobe, colStrobe, refStrobe}), 0);
    check(!done, "R1", "done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R1", "ready after reset", int'(reqReady), 1);
    check(!done && !rowStrobe && !colStrobe && !refStrobe, "R1", "quiet after reset",
          int'({done, rowStrobe, colStrobe, refStrobe}), 0);

    // Address-order writes: hits inside a row, dirty misses at row boundaries
    for (int a = 0; a < CELLS; a++) doOp(1, a, (a * 37 + 11) & 255);
    // Column-major reads: every access changes row
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) doOp(0, r * COLS + c, 0);
    // Row-major reads: mostly hits
    for (int a = 0; a < CELLS; a++) doOp(0, a, 0);
    // Reverse-order overwrite, then stride-5 reads
    for (int a = CELLS - 1; a >= 0; a--) doOp(1, a, ((a * 91 + 3) ^ 8'h5A) & 255);
    for (int i = 0; i < CELLS; i++) doOp(0, (i * 5) % CELLS, 0);
    // Boundary bytes written and read back on the open row
    doOp(1, 0, 8'h00);  doOp(0, 0, 0);
    doOp(1, 0, 8'hFF);  doOp(0, 0, 0);
    doOp(1, CELLS - 1, 8'hFF); doOp(0, CELLS - 1, 0);
    doOp(1, CELLS - 1, 8'h00); doOp(0, CELLS - 1, 0);
    check(refSeen > 0, "R8", "refreshes during traffic", refSeen, 1);

    // Idle stretch after a dirty write: spacing, survival and reopen
    doOp(1, 6, 8'hC3);
    begin
      int s;
      s = refSeen;
      wait (refSeen == s + 2);
      for (int k = 0; k < 4; k++) begin
        s = refSeen;
        wait (refSeen == s + 1);
        check(lastGap == REF_CYC, "R8", "idle refresh spacing", lastGap, REF_CYC);
      end
    end
    doOp(0, 6, 0);   // R9: closed by refresh, so a clean miss with a row strobe
    for (int a = 0; a < CELLS; a++) doOp(0, a, 0);   // R9: all data survived refresh

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule